// File: doc/BRIEF.md
# Four-Stage Configurable Watchdog

This block is a watchdog timer that walks through four timeout stages in turn. Each stage has its own timeout, counted in clock cycles, and its own action code. When a stage times out, its action fires, the counter returns to zero and the next stage begins. The last stage repeats its action on every further timeout until software feeds the watchdog. The actions are none, interrupt, CPU reset, system reset and always-on-domain reset. Reset actions come out as timed pulses. A separate reset distribution network acts on those pulses.

Software turns the watchdog on with one enable bit and keeps it quiet by pulsing the feed input, which restarts the sequence. Counting can be frozen while a sleep input is high. Two enables choose which CPU a CPU-reset action reaches. Two more enables choose a sticky level interrupt, a one-cycle edge interrupt, or both. Two 3-bit length fields set the width of the CPU reset pulse and of the system reset pulse.

The sequencer is a five-state machine:
- `WD_OFF`: the watchdog is idle.
- `WD_STAGE0` to `WD_STAGE3`: one state for each stage.

Its transitions are:
- enable taken: `WD_OFF` to `WD_STAGE0`.
- timeout: `WD_STAGE0` to `WD_STAGE1`, `WD_STAGE1` to `WD_STAGE2`, `WD_STAGE2` to `WD_STAGE3`.
- repeat: `WD_STAGE3` to `WD_STAGE3`.
- feed: any stage to `WD_STAGE0`.
- disable: any state to `WD_OFF`.

Top module: `staged_watchdog`

## Requirements
- R1: After reset every output (`irq_level`, `irq_edge`, `cpu0_rst`, `cpu1_rst`, `sys_rst`, `aon_rst`) is low.
- R2: While `wd_enable` is low the watchdog does not count, fires no action, and holds `irq_level` low from the cycle after the drop. Raising `wd_enable` starts stage 0 with the count at zero. The stage 0 action becomes visible T0 rising edges after the edge that samples the enable.
- R3: A stage with timeout T (bits `[32*k +: 32]` of `stage_limit` for stage k) expires after T counted cycles, and a timeout of 0 behaves as 1. On expiry the next stage begins with the count at zero. Stage 3 stays current and repeats its action every T3 cycles.
- R4: The action code of stage k is bits `[3*k +: 3]` of `stage_act`. Code 0 does nothing, 1 raises the interrupt, 2 resets the CPUs, 3 resets the system, and 4 resets the always-on domain. Codes 5 to 7 do nothing.
- R5: A one-cycle `feed` returns the sequencer to stage 0 with the count at zero and clears `irq_level`. A feed in the cycle where a stage would expire suppresses that expiry.
- R6: When `sleep_pause_en` and `sleep_in` are both high, the count is frozen and nothing fires. Otherwise `sleep_in` has no effect.
- R7: A CPU-reset action pulses `cpu0_rst` only if `cpu0_rst_en` is high, and `cpu1_rst` only if `cpu1_rst_en` is high. Each enable is sampled at the expiry.
- R8: A CPU reset pulse lasts 2^(`cpu_len`+1) cycles. System and always-on reset pulses last 2^(`sys_len`+1) cycles.
- R9: An interrupt action sets `irq_level` (when `irq_level_en` is high) until a feed or disable clears it. It also pulses `irq_edge` high for one cycle (when `irq_edge_en` is high).
- R10: A reset action that fires while its pulse is still high reloads the pulse to its full length from the new expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_enable | input | 1 | Global watchdog enable |
| feed | input | 1 | One-cycle restart request |
| sleep_pause_en | input | 1 | Freeze counting while asleep |
| sleep_in | input | 1 | Sleep indication |
| cpu0_rst_en | input | 1 | Let CPU-reset actions reach CPU 0 |
| cpu1_rst_en | input | 1 | Let CPU-reset actions reach CPU 1 |
| irq_level_en | input | 1 | Enable the level interrupt |
| irq_edge_en | input | 1 | Enable the edge interrupt |
| cpu_len | input | 3 | CPU reset pulse length code |
| sys_len | input | 3 | System and always-on reset pulse length code |
| stage_act | input | 12 | Action codes, 3 bits per stage, stage 0 lowest |
| stage_limit | input | 128 | Timeouts, 32 bits per stage, stage 0 lowest |
| irq_level | output | 1 | Sticky interrupt |
| irq_edge | output | 1 | One-cycle interrupt pulse |
| cpu0_rst | output | 1 | CPU 0 reset pulse |
| cpu1_rst | output | 1 | CPU 1 reset pulse |
| sys_rst | output | 1 | System reset pulse |
| aon_rst | output | 1 | Always-on-domain reset pulse |

## Verification
The bench builds the block with its defaults: 32-bit stage counters and 3-bit length codes. With stage timeouts programmed in single digits, a 30-cycle window covers all four stages and several repeats of stage 3. Because the length field reaches its maximum code, the longest 256-cycle reset pulse and a reload during a live pulse are both exercised in full.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int WD_STAGES = 4;
    localparam int WD_ACT_W  = 3;

    // Reset-pulse channels
    localparam int PULSE_CH = 4;
    localparam int CH_CPU0  = 0;
    localparam int CH_CPU1  = 1;
    localparam int CH_SYS   = 2;
    localparam int CH_AON   = 3;

    typedef enum logic [2:0] {
        WD_OFF    = 3'd0,
        WD_STAGE0 = 3'd1,
        WD_STAGE1 = 3'd2,
        WD_STAGE2 = 3'd3,
        WD_STAGE3 = 3'd4
    } wd_state_e;

    // Action codes; other values do nothing
    localparam logic [WD_ACT_W-1:0] ACT_NONE = 3'd0;
    localparam logic [WD_ACT_W-1:0] ACT_IRQ  = 3'd1;
    localparam logic [WD_ACT_W-1:0] ACT_CPU  = 3'd2;
    localparam logic [WD_ACT_W-1:0] ACT_SYS  = 3'd3;
    localparam logic [WD_ACT_W-1:0] ACT_AON  = 3'd4;

endpackage

// File: rtl/wdt_stage_seq.sv
module wdt_stage_seq
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enable,
    input  logic                          hold,
    input  logic                          feed,
    input  logic [WD_STAGES*CNT_W-1:0]    limits,
    input  logic [WD_STAGES*WD_ACT_W-1:0] actions,
    output logic                          fire,
    output logic [WD_ACT_W-1:0]           fire_act
);

    localparam int IDX_W = $clog2(WD_STAGES);

    wd_state_e        state_q;
    wd_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] stg_idx;
    logic [CNT_W-1:0] cur_limit;
    logic             running;
    logic             count_on;
    logic             expire;

    // Stage index of the current state
    always_comb begin : idx_decode
        unique case (state_q)
            WD_STAGE1: stg_idx = IDX_W'(1);
            WD_STAGE2: stg_idx = IDX_W'(2);
            WD_STAGE3: stg_idx = IDX_W'(3);
            default:   stg_idx = '0;
        endcase
    end

    assign running   = (state_q != WD_OFF);
    assign cur_limit = limits[stg_idx*CNT_W +: CNT_W];
    assign count_on  = running && enable && !hold && !feed;
    // Zero timeout behaves as one counted cycle
    assign expire    = count_on &&
                       (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, cur_limit});

    // Next-state logic
    always_comb begin : next_state
        state_d = state_q;
        unique case (state_q)
            WD_OFF: begin
                if (enable) state_d = WD_STAGE0;
            end
            WD_STAGE0: begin
                if (!enable)     state_d = WD_OFF;
                else if (feed)   state_d = WD_STAGE0;
                else if (expire) state_d = WD_STAGE1;
            end
            WD_STAGE1: begin
                if (!enable)     state_d = WD_OFF;
                else if (feed)   state_d = WD_STAGE0;
                else if (expire) state_d = WD_STAGE2;
            end
            WD_STAGE2: begin
                if (!enable)     state_d = WD_OFF;
                else if (feed)   state_d = WD_STAGE0;
                else if (expire) state_d = WD_STAGE3;
            end
            WD_STAGE3: begin
                if (!enable)     state_d = WD_OFF;
                else if (feed)   state_d = WD_STAGE0;
            end
            default: state_d = WD_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin : state_reg
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    // Stage counter
    always_ff @(posedge clk or negedge rst_n) begin : stage_cnt
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || !running || feed || expire) begin
            cnt_q <= '0;
        end else if (!hold) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin : outputs
        fire     = expire;
        fire_act = actions[stg_idx*WD_ACT_W +: WD_ACT_W];
    end

endmodule

// File: rtl/wdt_act_decode.sv
module wdt_act_decode
    import wdt_pkg::*;
(
    input  logic                fire,
    input  logic [WD_ACT_W-1:0] fire_act,
    input  logic                cpu0_en,
    input  logic                cpu1_en,
    input  logic                lvl_en,
    input  logic                edge_en,
    output logic [PULSE_CH-1:0] trig,
    output logic                set_level,
    output logic                edge_now
);

    always_comb begin : decode
        trig      = '0;
        set_level = 1'b0;
        edge_now  = 1'b0;
        if (fire) begin
            unique case (fire_act)
                ACT_IRQ: begin
                    set_level = lvl_en;
                    edge_now  = edge_en;
                end
                ACT_CPU: begin
                    trig[CH_CPU0] = cpu0_en;
                    trig[CH_CPU1] = cpu1_en;
                end
                ACT_SYS: trig[CH_SYS] = 1'b1;
                ACT_AON: trig[CH_AON] = 1'b1;
                default: trig = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [LEN_W-1:0] len,
    output logic             pulse
);

    // Longest pulse is 2^(2^LEN_W) cycles
    localparam int CW = (1 << LEN_W) + 1;

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin : remain_reg
        if (!rst_n) begin
            remain_q <= '0;
        end else if (trig) begin
            remain_q <= CW'(1) << (int'(len) + 1);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - CW'(1);
        end
    end

    assign pulse = (remain_q != '0);

endmodule

// File: rtl/staged_watchdog.sv
module staged_watchdog
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wd_enable,
    input  logic                          feed,
    input  logic                          sleep_pause_en,
    input  logic                          sleep_in,
    input  logic                          cpu0_rst_en,
    input  logic                          cpu1_rst_en,
    input  logic                          irq_level_en,
    input  logic                          irq_edge_en,
    input  logic [LEN_W-1:0]              cpu_len,
    input  logic [LEN_W-1:0]              sys_len,
    input  logic [WD_STAGES*WD_ACT_W-1:0] stage_act,
    input  logic [WD_STAGES*CNT_W-1:0]    stage_limit,
    output logic                          irq_level,
    output logic                          irq_edge,
    output logic                          cpu0_rst,
    output logic                          cpu1_rst,
    output logic                          sys_rst,
    output logic                          aon_rst
);

    logic                fire;
    logic [WD_ACT_W-1:0] fire_act;
    logic [PULSE_CH-1:0] trig;
    logic [PULSE_CH-1:0] pulses;
    logic                set_level;
    logic                edge_now;
    logic                hold;

    assign hold = sleep_pause_en && sleep_in;

    wdt_stage_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (wd_enable),
        .hold     (hold),
        .feed     (feed),
        .limits   (stage_limit),
        .actions  (stage_act),
        .fire     (fire),
        .fire_act (fire_act)
    );

    wdt_act_decode u_dec (
        .fire      (fire),
        .fire_act  (fire_act),
        .cpu0_en   (cpu0_rst_en),
        .cpu1_en   (cpu1_rst_en),
        .lvl_en    (irq_level_en),
        .edge_en   (irq_edge_en),
        .trig      (trig),
        .set_level (set_level),
        .edge_now  (edge_now)
    );

    // One pulse generator per reset channel; CPU channels use cpu_len
    for (genvar ch = 0; ch < PULSE_CH; ch++) begin : g_pulse
        logic [LEN_W-1:0] ch_len;
        if (ch == CH_CPU0 || ch == CH_CPU1) begin : g_cpu
            assign ch_len = cpu_len;
        end else begin : g_sys
            assign ch_len = sys_len;
        end
        wdt_pulse_gen #(.LEN_W(LEN_W)) u_pg (
            .clk   (clk),
            .rst_n (rst_n),
            .trig  (trig[ch]),
            .len   (ch_len),
            .pulse (pulses[ch])
        );
    end

    assign cpu0_rst = pulses[CH_CPU0];
    assign cpu1_rst = pulses[CH_CPU1];
    assign sys_rst  = pulses[CH_SYS];
    assign aon_rst  = pulses[CH_AON];

    // Interrupt outputs
    always_ff @(posedge clk or negedge rst_n) begin : irq_reg
        if (!rst_n) begin
            irq_level <= 1'b0;
            irq_edge  <= 1'b0;
        end else begin
            irq_edge <= edge_now;
            if (!wd_enable || feed) irq_level <= 1'b0;
            else if (set_level)     irq_level <= 1'b1;
        end
    end

endmodule

// File: rtl/staged_watchdog_chk.sv
module staged_watchdog_chk (
    input logic clk,
    input logic rst_n,
    input logic wd_enable,
    input logic feed,
    input logic sleep_pause_en,
    input logic sleep_in,
    input logic cpu0_rst_en,
    input logic irq_edge_en,
    input logic irq_level,
    input logic irq_edge,
    input logic cpu0_rst,
    input logic sys_rst
);

    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_enable |=> !irq_level);

    assert_feed_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        feed |=> !irq_level);

    assert_pause_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_level) |-> !$past(sleep_pause_en && sleep_in));

    assert_cpu0_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu0_rst) |-> $past(cpu0_rst_en));

    assert_sys_min_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |=> sys_rst);

    assert_edge_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_edge |-> $past(irq_edge_en));

endmodule

bind staged_watchdog staged_watchdog_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wd_enable      (wd_enable),
    .feed           (feed),
    .sleep_pause_en (sleep_pause_en),
    .sleep_in       (sleep_in),
    .cpu0_rst_en    (cpu0_rst_en),
    .irq_edge_en    (irq_edge_en),
    .irq_level      (irq_level),
    .irq_edge       (irq_edge),
    .cpu0_rst       (cpu0_rst),
    .sys_rst        (sys_rst)
);

// File: tb/tb_staged_watchdog.sv
`timescale 1ns/1ps
module tb_staged_watchdog;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wd_enable, feed, sleep_pause_en, sleep_in;
    logic         cpu0_rst_en, cpu1_rst_en, irq_level_en, irq_edge_en;
    logic [2:0]   cpu_len, sys_len;
    logic [11:0]  stage_act;
    logic [127:0] stage_limit;
    logic         irq_level, irq_edge, cpu0_rst, cpu1_rst, sys_rst, aon_rst;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    staged_watchdog dut (
        .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable), .feed(feed),
        .sleep_pause_en(sleep_pause_en), .sleep_in(sleep_in),
        .cpu0_rst_en(cpu0_rst_en), .cpu1_rst_en(cpu1_rst_en),
        .irq_level_en(irq_level_en), .irq_edge_en(irq_edge_en),
        .cpu_len(cpu_len), .sys_len(sys_len),
        .stage_act(stage_act), .stage_limit(stage_limit),
        .irq_level(irq_level), .irq_edge(irq_edge), .cpu0_rst(cpu0_rst),
        .cpu1_rst(cpu1_rst), .sys_rst(sys_rst), .aon_rst(aon_rst)
    );

    typedef struct packed {
        logic [2:0] act;
        logic [7:0] lim;
        logic       c0, c1, le, ee;
        logic [2:0] clen, slen;
        logic [8:0] e_c0, e_c1, e_sys, e_aon;
        logic [1:0] e_edge;
        logic       e_lvl;
        logic [8:0] e_first;
    } vec_t;

    // Stage 0 action under test; expected pulse widths, counts, first cycle
    localparam vec_t VECS [12] = '{
        '{3'd0, 8'd5, 1'b1, 1'b1, 1'b1, 1'b1, 3'd1, 3'd1, 9'd0, 9'd0,   9'd0, 9'd0,  2'd0, 1'b0, 9'd0},
        '{3'd1, 8'd5, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 3'd0, 9'd0, 9'd0,   9'd0, 9'd0,  2'd1, 1'b1, 9'd6},
        '{3'd1, 8'd3, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd0, 9'd0, 9'd0,   9'd0, 9'd0,  2'd1, 1'b0, 9'd4},
        '{3'd1, 8'd7, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 9'd0, 9'd0,   9'd0, 9'd0,  2'd0, 1'b1, 9'd8},
        '{3'd2, 8'd4, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 3'd0, 9'd2, 9'd0,   9'd0, 9'd0,  2'd0, 1'b0, 9'd5},
        '{3'd2, 8'd4, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, 3'd0, 9'd8, 9'd8,   9'd0, 9'd0,  2'd0, 1'b0, 9'd5},
        '{3'd2, 8'd2, 1'b0, 1'b1, 1'b0, 1'b0, 3'd7, 3'd0, 9'd0, 9'd256, 9'd0, 9'd0,  2'd0, 1'b0, 9'd3},
        '{3'd3, 8'd6, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 3'd1, 9'd0, 9'd0,   9'd4, 9'd0,  2'd0, 1'b0, 9'd7},
        '{3'd4, 8'd6, 1'b1, 1'b1, 1'b1, 1'b1, 3'd5, 3'd3, 9'd0, 9'd0,   9'd0, 9'd16, 2'd0, 1'b0, 9'd7},
        '{3'd5, 8'd3, 1'b1, 1'b1, 1'b1, 1'b1, 3'd1, 3'd1, 9'd0, 9'd0,   9'd0, 9'd0,  2'd0, 1'b0, 9'd0},
        '{3'd2, 8'd3, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 3'd3, 9'd0, 9'd0,   9'd0, 9'd0,  2'd0, 1'b0, 9'd0},
        '{3'd2, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0, 9'd4, 9'd0,   9'd0, 9'd0,  2'd0, 1'b0, 9'd2}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wd_enable = 1'b0; feed = 1'b0;
        sleep_pause_en = 1'b0; sleep_in = 1'b0;
        cpu0_rst_en = 1'b0; cpu1_rst_en = 1'b0;
        irq_level_en = 1'b0; irq_edge_en = 1'b0;
        cpu_len = '0; sys_len = '0;
        stage_act = '0; stage_limit = {4{32'd1000}};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic bit any_out();
        return irq_level | irq_edge | cpu0_rst | cpu1_rst | sys_rst | aon_rst;
    endfunction

    task automatic run_vec(input int idx);
        vec_t v;
        int n0, n1, ns, na, ne, first;
        v = VECS[idx];
        n0 = 0; n1 = 0; ns = 0; na = 0; ne = 0; first = 0;
        do_reset();
        stage_act    = {9'd0, v.act};
        stage_limit  = {32'd1000, 32'd1000, 32'd1000, 24'd0, v.lim};
        cpu0_rst_en  = v.c0; cpu1_rst_en = v.c1;
        irq_level_en = v.le; irq_edge_en = v.ee;
        cpu_len      = v.clen; sys_len = v.slen;
        wd_enable    = 1'b1;
        for (int n = 1; n <= 300; n++) begin
            @(negedge clk);
            n0 += int'(cpu0_rst); n1 += int'(cpu1_rst);
            ns += int'(sys_rst);  na += int'(aon_rst);
            ne += int'(irq_edge);
            if (first == 0 && any_out()) first = n;
        end
        chk($sformatf("R7 R8 vec%0d cpu0 cycles", idx), n0, int'(v.e_c0));
        chk($sformatf("R7 R8 vec%0d cpu1 cycles", idx), n1, int'(v.e_c1));
        chk($sformatf("R8 vec%0d sys cycles", idx), ns, int'(v.e_sys));
        chk($sformatf("R8 vec%0d aon cycles", idx), na, int'(v.e_aon));
        chk($sformatf("R9 vec%0d edge count", idx), ne, int'(v.e_edge));
        chk($sformatf("R9 vec%0d level at end", idx), int'(irq_level), int'(v.e_lvl));
        chk($sformatf("R4 R3 vec%0d first action cycle", idx), first, int'(v.e_first));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int edges [6];
        int ecount;
        int lv [41];
        int hi, last;

        // R1: reset state
        do_reset();
        chk("R1 outputs after reset", int'(any_out()), 0);

        // Table of stage 0 actions (R4, R7, R8, R9)
        for (int i = 0; i < 12; i++) run_vec(i);

        // R3: stage sequence and stage 3 repeat
        do_reset();
        stage_act   = {3'd1, 3'd1, 3'd1, 3'd1};
        stage_limit = {32'd4, 32'd2, 32'd5, 32'd3};
        irq_edge_en = 1'b1;
        wd_enable   = 1'b1;
        ecount = 0;
        for (int n = 1; n <= 30; n++) begin
            @(negedge clk);
            if (irq_edge && ecount < 6) begin
                edges[ecount] = n;
                ecount++;
            end
        end
        chk("R3 stage0 expiry", edges[0], 4);
        chk("R3 stage1 expiry", edges[1], 9);
        chk("R3 stage2 expiry", edges[2], 11);
        chk("R3 stage3 expiry", edges[3], 15);
        chk("R3 stage3 repeat one", edges[4], 19);
        chk("R3 stage3 repeat two", edges[5], 23);

        // R5: feed restarts, clears level, wins over expiry
        do_reset();
        stage_act    = 12'd1;
        stage_limit  = {32'd1000, 32'd1000, 32'd1000, 32'd10};
        irq_level_en = 1'b1;
        wd_enable    = 1'b1;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            lv[n] = int'(irq_level);
            feed = (n + 1 == 7) || (n + 1 == 18) || (n + 1 == 28);
        end
        feed = 1'b0;
        chk("R5 no fire before restarted timeout", lv[16], 0);
        chk("R5 fire after restart", lv[17], 1);
        chk("R5 feed clears level", lv[18], 0);
        chk("R5 feed suppresses expiry", lv[28], 0);
        chk("R5 still quiet before new timeout", lv[37], 0);
        chk("R5 fire after suppressed expiry", lv[38], 1);

        // R6: pause in sleep
        do_reset();
        stage_act      = 12'd1;
        stage_limit    = {32'd1000, 32'd1000, 32'd1000, 32'd10};
        irq_level_en   = 1'b1;
        sleep_pause_en = 1'b1;
        wd_enable      = 1'b1;
        for (int n = 1; n <= 20; n++) begin
            @(negedge clk);
            lv[n] = int'(irq_level);
            sleep_in = (n + 1 >= 3) && (n + 1 <= 7);
        end
        chk("R6 paused count delays fire", lv[15], 0);
        chk("R6 fire after pause", lv[16], 1);

        do_reset();
        stage_act    = 12'd1;
        stage_limit  = {32'd1000, 32'd1000, 32'd1000, 32'd10};
        irq_level_en = 1'b1;
        wd_enable    = 1'b1;
        for (int n = 1; n <= 20; n++) begin
            @(negedge clk);
            lv[n] = int'(irq_level);
            sleep_in = (n + 1 >= 3) && (n + 1 <= 7);
        end
        chk("R6 sleep ignored without pause", lv[10], 0);
        chk("R6 fire on time without pause", lv[11], 1);

        // R2: disable clears level, stays quiet, re-enable restarts
        wd_enable = 1'b0;
        @(negedge clk);
        chk("R2 disable clears level", int'(irq_level), 0);
        hi = 0;
        for (int n = 1; n <= 20; n++) begin
            @(negedge clk);
            hi += int'(any_out());
        end
        chk("R2 no action while disabled", hi, 0);
        wd_enable = 1'b1;
        for (int n = 1; n <= 11; n++) begin
            @(negedge clk);
            lv[n] = int'(irq_level);
        end
        chk("R2 re-enable starts stage0 quiet", lv[10], 0);
        chk("R2 re-enable fires after T0", lv[11], 1);

        // R10: retrigger reloads the pulse
        do_reset();
        stage_act   = {3'd0, 3'd0, 3'd2, 3'd2};
        stage_limit = {32'd1000, 32'd1000, 32'd2, 32'd3};
        cpu0_rst_en = 1'b1;
        cpu_len     = 3'd2;
        wd_enable   = 1'b1;
        hi = 0; last = 0;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            if (cpu0_rst) begin
                hi++;
                last = n;
            end
        end
        chk("R10 reloaded pulse total cycles", hi, 10);
        chk("R10 reloaded pulse last cycle", last, 13);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule